// File: doc/BRIEF.md
# T3/E3 Framing Error Tally

This block keeps the running count of framing-related errors for the receive side of a T3 or E3 framer. A two-bit selector chooses the event class. Selector 00 counts loss-of-frame occurrences in either line mode. In T3 mode the other three settings count F-bit and M-bit errors together, F-bit errors alone, or M-bit errors alone. In E3 mode they count errored bits inside the frame alignment word, or alignment words with at least one error. The fourth E3 setting is illegal: the block raises a flag and stops counting.

The framer gives one strobe per frame, with the error indications for that frame beside it, and a level that shows loss of frame. A control input decides if framed-information errors still count while loss of frame is present. A latch strobe moves the running total, including any event in that same cycle, into a held output register and restarts the running count from zero. In this way the reading covers one interval and no event is lost. The running count saturates and does not wrap.

Top module: `frm_err_tally`

## Requirements
- R1: After reset, latchedCount is 0, the running count is 0, and the first latch with no events in between returns 0.
- R2: With countSel = 00 (either line mode), the count rises by exactly one for each low-to-high transition of lofIn, however long lofIn stays high, and countInLof has no effect.
- R3: In T3 mode (e3Mode = 0) with countSel = 01, each cycle with frameStb high adds fBitErr + mBitErr (0, 1 or 2).
- R4: In T3 mode, countSel = 10 adds only fBitErr per frame and countSel = 11 adds only mBitErr per frame.
- R5: In E3 mode (e3Mode = 1) with countSel = 01, each frame adds fasErrBits (4 bits). Values above MAX_FAS_BITS (default 10) are clamped to MAX_FAS_BITS.
- R6: In E3 mode with countSel = 10, each frame with a nonzero fasErrBits adds exactly one.
- R7: E3 mode with countSel = 11 drives cfgIllegal high in the same cycle (combinational) and adds nothing. cfgIllegal is low for every other setting.
- R8: For countSel 01, 10 and 11: when countInLof = 0 and lofIn = 1, frame events add nothing. When countInLof = 1, they count normally during loss of frame.
- R9: A cycle with latchStb high loads latchedCount, at that clock edge, with the running count plus that cycle's increment, and the running count restarts from zero. latchedCount holds its value in every other cycle.
- R10: The running count saturates at 2^CNT_W - 1 and never wraps.
- R11: For countSel 01, 10 and 11, error inputs in cycles where frameStb is low add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| e3Mode | input | 1 | 1 = E3 line mode, 0 = T3 |
| countSel | input | 2 | Event class selector |
| countInLof | input | 1 | 1 = framed errors keep counting while lofIn is high |
| lofIn | input | 1 | Loss-of-frame status level |
| frameStb | input | 1 | One-cycle strobe per received frame |
| fBitErr | input | 1 | T3: F-bit error in this frame |
| mBitErr | input | 1 | T3: M-bit error in this frame |
| fasErrBits | input | 4 | E3: number of errored alignment-word bits in this frame |
| latchStb | input | 1 | Latch the running count and restart it |
| latchedCount | output | CNT_W | Count captured at the last latch |
| cfgIllegal | output | 1 | Illegal E3 selector setting |

## Verification
Any fault in the running count stays hidden until the next latch strobe. The bench therefore latches often, at random intervals, so that an error in edge detection, gating, clamping or selection appears in latchedCount one edge after the latch that closes the faulty interval. A missing restart after a latch carries the old total into the next reading and shows there. A wrapping counter shows as a small value after a long run of full-weight E3 frames. The illegal flag is combinational and is checked in the cycle in which the setting is applied.

// File: rtl/frm_err_pkg.sv
package frm_err_pkg;

  localparam int INC_W = 4;

  typedef enum logic [1:0] {
    SEL_LOF  = 2'b00,
    SEL_BOTH = 2'b01,
    SEL_FBIT = 2'b10,
    SEL_MBIT = 2'b11
  } err_sel_e;

  typedef struct packed {
    logic [INC_W-1:0] incAmt;
    logic             latchNow;
  } tally_strobe_t;

endpackage

// File: rtl/frm_err_ctrl.sv
module frm_err_ctrl
  import frm_err_pkg::*;
#(
  parameter int MAX_FAS_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             e3Mode,
  input  logic [1:0]       countSel,
  input  logic             countInLof,
  input  logic             lofIn,
  input  logic             frameStb,
  input  logic             fBitErr,
  input  logic             mBitErr,
  input  logic [INC_W-1:0] fasErrBits,
  input  logic             latchStb,
  output tally_strobe_t    strb,
  output logic             illegal
);

  localparam logic [INC_W-1:0] FAS_CAP = INC_W'(MAX_FAS_BITS);

  err_sel_e         selMode;
  logic             lofPrev;
  logic             lofRise;
  logic             frozen;
  logic [INC_W-1:0] t3Inc;
  logic [INC_W-1:0] e3Inc;
  logic [INC_W-1:0] framedInc;
  logic [INC_W-1:0] clampedBits;

  assign selMode = err_sel_e'(countSel);

  always_ff @(posedge clk) begin
    if (!rstN) lofPrev <= 1'b0;
    else       lofPrev <= lofIn;
  end

  assign lofRise = lofIn && !lofPrev;
  assign frozen  = lofIn && !countInLof;

  always_comb begin
    clampedBits = (fasErrBits > FAS_CAP) ? FAS_CAP : fasErrBits;
  end

  always_comb begin
    t3Inc = '0;
    unique case (selMode)
      SEL_BOTH: t3Inc = INC_W'(fBitErr) + INC_W'(mBitErr);
      SEL_FBIT: t3Inc = INC_W'(fBitErr);
      SEL_MBIT: t3Inc = INC_W'(mBitErr);
      default:  t3Inc = '0;
    endcase
  end

  always_comb begin
    e3Inc = '0;
    unique case (selMode)
      SEL_BOTH: e3Inc = clampedBits;
      SEL_FBIT: e3Inc = INC_W'(fasErrBits != '0);
      default:  e3Inc = '0;
    endcase
  end

  assign illegal = e3Mode && (selMode == SEL_MBIT);

  always_comb begin
    framedInc = e3Mode ? e3Inc : t3Inc;
    if (!frameStb || frozen || illegal) framedInc = '0;
  end

  always_comb begin
    strb.latchNow = latchStb;
    if (selMode == SEL_LOF) strb.incAmt = INC_W'(lofRise);
    else                    strb.incAmt = framedInc;
  end

  // R2: a held loss of frame adds nothing after its first cycle
  p_lof_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    (selMode == SEL_LOF && lofIn && lofPrev) |-> strb.incAmt == '0);

  // R8: frozen framed counting during loss of frame
  p_lof_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selMode != SEL_LOF && lofIn && !countInLof) |-> strb.incAmt == '0);

  // R5: no increment beyond the clamp
  p_inc_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.incAmt <= FAS_CAP);

  // R11: no framed events outside a frame strobe
  p_frame_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    (selMode != SEL_LOF && !frameStb) |-> strb.incAmt == '0);

endmodule

// File: rtl/frm_err_dp.sv
module frm_err_dp
  import frm_err_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tally_strobe_t    strb,
  output logic [CNT_W-1:0] latchedCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] runCount;
  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] sumSat;

  assign sumWide = {1'b0, runCount} + {{(CNT_W+1-INC_W){1'b0}}, strb.incAmt};
  assign sumSat  = sumWide[CNT_W] ? CNT_MAX : sumWide[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCount     <= '0;
      latchedCount <= '0;
    end else if (strb.latchNow) begin
      runCount     <= '0;
      latchedCount <= sumSat;
    end else begin
      runCount     <= sumSat;
    end
  end

  // R10: saturated count does not wrap
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (runCount == CNT_MAX && !strb.latchNow) |=> runCount == CNT_MAX);

  // R9: held reading between latches
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchNow |=> $stable(latchedCount));

  // R9: running count restarts after a latch
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchNow |=> runCount == '0);

  // R10: count never decreases without a latch
  p_monotonic_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchNow |=> runCount >= $past(runCount));

endmodule

// File: rtl/frm_err_tally.sv
module frm_err_tally
  import frm_err_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int MAX_FAS_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             e3Mode,
  input  logic [1:0]       countSel,
  input  logic             countInLof,
  input  logic             lofIn,
  input  logic             frameStb,
  input  logic             fBitErr,
  input  logic             mBitErr,
  input  logic [3:0]       fasErrBits,
  input  logic             latchStb,
  output logic [CNT_W-1:0] latchedCount,
  output logic             cfgIllegal
);

  tally_strobe_t strb;

  frm_err_ctrl #(.MAX_FAS_BITS(MAX_FAS_BITS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .e3Mode     (e3Mode),
    .countSel   (countSel),
    .countInLof (countInLof),
    .lofIn      (lofIn),
    .frameStb   (frameStb),
    .fBitErr    (fBitErr),
    .mBitErr    (mBitErr),
    .fasErrBits (fasErrBits),
    .latchStb   (latchStb),
    .strb       (strb),
    .illegal    (cfgIllegal)
  );

  frm_err_dp #(.CNT_W(CNT_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .latchedCount (latchedCount)
  );

  // R7: illegal setting adds nothing to the reading
  p_illegal_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIllegal && !latchStb) |=> $stable(latchedCount));

endmodule

// File: tb/frm_err_tally_tb_top.sv
module frm_err_tally_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int MAXC       = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             e3Mode = 1'b0;
  logic [1:0]       countSel = 2'b00;
  logic             countInLof = 1'b0;
  logic             lofIn = 1'b0;
  logic             frameStb = 1'b0;
  logic             fBitErr = 1'b0;
  logic             mBitErr = 1'b0;
  logic [3:0]       fasErrBits = 4'd0;
  logic             latchStb = 1'b0;
  logic [CNT_W-1:0] latchedCount;
  logic             cfgIllegal;

  int nChecks = 0;
  int nFails  = 0;
  int mRun    = 0;
  int mLatched = 0;
  bit mLofPrev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frm_err_tally #(.CNT_W(CNT_W), .MAX_FAS_BITS(10)) dut_i (
    .clk(clk), .rstN(rstN), .e3Mode(e3Mode), .countSel(countSel),
    .countInLof(countInLof), .lofIn(lofIn), .frameStb(frameStb),
    .fBitErr(fBitErr), .mBitErr(mBitErr), .fasErrBits(fasErrBits),
    .latchStb(latchStb), .latchedCount(latchedCount), .cfgIllegal(cfgIllegal)
  );

  function automatic int expInc(bit e3, bit [1:0] sel, bit inLof, bit lof,
                                bit prev, bit frm, bit f, bit m, int bits);
    if (sel == 2'b00) return (lof && !prev) ? 1 : 0;
    if (e3 && sel == 2'b11) return 0;
    if (!frm) return 0;
    if (lof && !inLof) return 0;
    if (!e3) begin
      if (sel == 2'b01) return int'(f) + int'(m);
      if (sel == 2'b10) return int'(f);
      return int'(m);
    end
    if (sel == 2'b01) return (bits > 10) ? 10 : bits;
    return (bits != 0) ? 1 : 0;
  endfunction

  function automatic int satAdd(int a, int b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // one cycle: drive at negedge, model at posedge, return at next negedge
  task automatic cyc(bit e3, bit [1:0] sel, bit inLof, bit lof, bit frm,
                     bit f, bit m, int bits, bit lat);
    int inc;
    e3Mode = e3; countSel = sel; countInLof = inLof; lofIn = lof;
    frameStb = frm; fBitErr = f; mBitErr = m; fasErrBits = 4'(bits);
    latchStb = lat;
    @(posedge clk);
    inc = expInc(e3, sel, inLof, lof, mLofPrev, frm, f, m, bits);
    mLofPrev = lof;
    if (lat) begin
      mLatched = satAdd(mRun, inc);
      mRun = 0;
    end else begin
      mRun = satAdd(mRun, inc);
    end
    @(negedge clk);
  endtask

  task automatic latchCheck(string req, bit e3, bit [1:0] sel);
    cyc(e3, sel, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    check(req, int'(latchedCount), mLatched);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", int'(latchedCount), 0);
    check("R1 illegal", int'(cfgIllegal), 0);
    latchCheck("R1", 1'b0, 2'b01);
    check("R1 value", int'(latchedCount), 0);

    // R2 LOF occurrences, held high counts once, gating ignored
    for (int k = 0; k < 3; k++) begin
      repeat (4) cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 5, 1'b0);
      repeat (2) cyc(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    end
    latchCheck("R2", 1'b0, 2'b00);
    check("R2 three rises", int'(latchedCount), 3);
    repeat (3) cyc(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    latchCheck("R2", 1'b1, 2'b00);
    check("R2 E3 one rise", int'(latchedCount), 1);

    // R3 T3 both bits
    cyc(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    cyc(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    cyc(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    latchCheck("R3", 1'b0, 2'b01);
    check("R3 sum", int'(latchedCount), 4);

    // R4 F only, then M only
    cyc(1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    cyc(1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    latchCheck("R4", 1'b0, 2'b10);
    check("R4 fbit", int'(latchedCount), 1);
    repeat (3) cyc(1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    cyc(1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    latchCheck("R4", 1'b0, 2'b11);
    check("R4 mbit", int'(latchedCount), 3);

    // R5 E3 bit count with clamp
    cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7, 1'b0);
    cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 15, 1'b0);
    latchCheck("R5", 1'b1, 2'b01);
    check("R5 clamp", int'(latchedCount), 17);

    // R6 E3 word errors
    cyc(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9, 1'b0);
    cyc(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    cyc(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    latchCheck("R6", 1'b1, 2'b10);
    check("R6 words", int'(latchedCount), 2);

    // R7 illegal flag and no counting
    e3Mode = 1'b1; countSel = 2'b11; #1;
    check("R7 flag", int'(cfgIllegal), 1);
    e3Mode = 1'b0; #1;
    check("R7 T3 legal", int'(cfgIllegal), 0);
    repeat (4) cyc(1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10, 1'b0);
    latchCheck("R7", 1'b1, 2'b11);
    check("R7 no count", int'(latchedCount), 0);

    // R8 LOF gating
    repeat (3) cyc(1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    latchCheck("R8", 1'b0, 2'b01);
    check("R8 frozen", int'(latchedCount), 0);
    repeat (3) cyc(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b0);
    latchCheck("R8", 1'b1, 2'b01);
    check("R8 allowed", int'(latchedCount), 12);

    // R11 no frame strobe
    repeat (3) cyc(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    latchCheck("R11", 1'b0, 2'b01);
    check("R11 ignored", int'(latchedCount), 0);

    // R9 latch includes same-cycle event, reading holds
    cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3, 1'b0);
    cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5, 1'b1);
    check("R9 same cycle", int'(latchedCount), 8);
    repeat (3) cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2, 1'b0);
    check("R9 hold", int'(latchedCount), 8);
    latchCheck("R9", 1'b1, 2'b01);
    check("R9 restart", int'(latchedCount), 6);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit rl;
      rl = ($urandom_range(7) == 0);
      cyc(1'($urandom_range(1)), 2'($urandom_range(3)), 1'($urandom_range(1)),
          ($urandom_range(3) == 0), 1'($urandom_range(1)), 1'($urandom_range(1)),
          1'($urandom_range(1)), $urandom_range(15), rl);
      if (rl) check("R9 random", int'(latchedCount), mLatched);
    end
    latchCheck("R9", 1'b0, 2'b01);

    // R10 saturation
    for (int i = 0; i < 6700; i++)
      cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10, 1'b0);
    latchCheck("R10", 1'b1, 2'b01);
    check("R10 max", int'(latchedCount), MAXC);
    cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10, 1'b0);
    latchCheck("R10", 1'b1, 2'b01);
    check("R10 after", int'(latchedCount), 10);

    finishRun();
  end

endmodule